// File: doc/BRIEF.md
# Five-Channel Down-Counting Timer Bank

This block holds five independent 32-bit down counters behind a 32-bit memory-mapped register window. Each channel has a count buffer that software preloads, a live count that software can read back, and (on channels 0 to 3) a compare buffer that is only stored and returned. One packed control word carries each channel's run, reload-strobe, invert and auto-repeat bits. Two configuration words are plain storage for the external prescaler that produces the per-channel tick enables.

A channel runs while its run bit is set and moves down by one on every tick. When a tick arrives while the count already sits at zero, the channel expires. It emits a one-cycle expire pulse, and then either refills from its buffer and keeps going, or stops and clears its own run bit. Reload and run act on the rising edges of the bits that software writes, so rewriting a control word with the same values is harmless.

Top module: `cdt_ctrl`

## Requirements
- R1: After reset every readable register, including the control word, the configuration words and all live counts, reads 0. No channel runs and `expire` is 0.
- R2: The register offsets are fixed. Configuration words sit at 0x00 and 0x04 and the control word at 0x08. For channel n < 4, the count buffer is at 0x0C+12n, the compare buffer at 0x10+12n and the live count at 0x14+12n. Channel 4 has its count buffer at 0x3C and its live count at 0x40. The read/write registers return what was written, and the live count reads the current counter value.
- R3: In the control word, channel 0's group starts at bit 0 and channels 1, 2, 3 and 4 start at bits 8, 12, 16 and 20. Within a group, +0 is run, +1 is reload strobe, +2 is invert and +3 is auto-repeat. Channel 4 has no invert bit, so its auto-repeat bit is bit 22.
- R4: A control write that takes a channel's reload-strobe bit from 0 to 1 copies that channel's count buffer into its live count at that write's clock edge. A write that leaves the bit at 1 does not reload.
- R5: While its run bit is 1, a channel's count drops by one on each cycle its tick enable is high. It does not change in cycles without a tick, and it does not change while the run bit is 0.
- R6: Clearing a run bit stops the channel. Later ticks leave its live count unchanged.
- R7: A tick on a running channel whose count is 0 is an expiry. It raises that channel's `expire` bit for exactly the one cycle after that edge, with or without auto-repeat.
- R8: On expiry with auto-repeat set, the count is refilled from the count buffer and the run bit stays 1.
- R9: On expiry with auto-repeat clear, the channel stops at count 0 and the hardware clears its run bit in the control word. A control write in the same cycle takes precedence.
- R10: When one write raises both the reload-strobe and run bits, the load happens first. The first tick after the write counts down from the buffer value.
- R11: Reads of unmapped or misaligned offsets (0x44 and above, or any address not a multiple of 4) return 0. Writes to those offsets, and writes to live-count offsets, change nothing.
- R12: Channels are independent. A tick or expiry on one channel does not disturb the others, and simultaneous expiries raise their `expire` bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register window |
| bus_addr | input | 7 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_en | input | 5 | Per-channel count enable from the prescaler |
| expire | output | 5 | One-cycle expiry pulse per channel |

## Verification
The bench goes after the edge-driven control semantics. It rewrites an already-set reload strobe, which a level-sensitive design would answer with a spurious reload. It raises strobe and run in one write, which would lose one count if counting began before the load. It then lets one-shot and auto-repeat channels expire, where a wrong design would keep running, fail to clear the run bit, or drop the pulse on refill. It also drives simultaneous expiries on channels 2 and 4 and checks channel 4's shifted auto-repeat bit, where a layout slip would make that channel stop instead of refilling. A pulse that lasts longer than one cycle shows up as an expire event with no expected entry in the scoreboard.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int NCH = 5;   // register layout is fixed for five channels
    localparam int DW  = 32;
    localparam int AW  = 7;
    localparam int CHW = $clog2(NCH);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG0,
        SEL_CFG1,
        SEL_CTL,
        SEL_CNTBUF,
        SEL_CMPBUF,
        SEL_LIVE
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e        kind;
        logic [CHW-1:0]   ch;
    } reg_sel_t;

    // first bit of a channel's control group
    function automatic int grp_base(input int ch);
        return (ch == 0) ? 0 : 4 + 4 * ch;
    endfunction

    function automatic int run_bit(input int ch);
        return grp_base(ch);
    endfunction

    function automatic int strobe_bit(input int ch);
        return grp_base(ch) + 1;
    endfunction

    // the last channel lacks an invert bit, so auto-repeat slides down
    function automatic int repeat_bit(input int ch);
        return (ch == NCH - 1) ? grp_base(ch) + 2 : grp_base(ch) + 3;
    endfunction

    function automatic reg_sel_t decode(input logic [AW-1:0] a);
        reg_sel_t s;
        s.kind = SEL_NONE;
        s.ch   = '0;
        if (a == AW'(0))  s.kind = SEL_CFG0;
        if (a == AW'(4))  s.kind = SEL_CFG1;
        if (a == AW'(8))  s.kind = SEL_CTL;
        for (int ch = 0; ch < NCH; ch++) begin
            int b;
            b = 12 + 12 * ch;
            if (a == AW'(b)) begin
                s.kind = SEL_CNTBUF;
                s.ch   = CHW'(ch);
            end
            if (ch < NCH - 1) begin
                if (a == AW'(b + 4)) begin
                    s.kind = SEL_CMPBUF;
                    s.ch   = CHW'(ch);
                end
                if (a == AW'(b + 8)) begin
                    s.kind = SEL_LIVE;
                    s.ch   = CHW'(ch);
                end
            end else if (a == AW'(b + 4)) begin
                s.kind = SEL_LIVE;
                s.ch   = CHW'(ch);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/cdt_chan.sv
module cdt_chan #(
    parameter int W = cdt_pkg::DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         load_i,
    input  logic         rpt_i,
    input  logic [W-1:0] buf_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o,
    output logic         expire_o
);

    logic [W-1:0] cnt_q;
    logic         exp_q;

    // a load in the same cycle pre-empts counting
    assign hit_o = run_i && tick_i && !load_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= hit_o;
            if (load_i) begin
                cnt_q <= buf_i;
            end else if (run_i && tick_i) begin
                if (cnt_q == '0) begin
                    if (rpt_i) cnt_q <= buf_i;
                end else begin
                    cnt_q <= cnt_q - W'(1);
                end
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = exp_q;

    // R4
    load_val_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == $past(buf_i));

    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && tick_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - W'(1));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !(run_i && tick_i)) |=> $stable(cnt_q));

    // R7
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        expire_o |-> $past(run_i && tick_i && cnt_q == '0));

endmodule

// File: rtl/cdt_ctl.sv
module cdt_ctl #(
    parameter int W = cdt_pkg::DW,
    parameter int N = cdt_pkg::NCH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic [N-1:0] hit_i,
    output logic [W-1:0] ctl_o,
    output logic [N-1:0] run_o,
    output logic [N-1:0] load_o,
    output logic [N-1:0] rpt_o
);
    import cdt_pkg::*;

    logic [W-1:0] ctl_q;
    logic [W-1:0] clr_mask;

    for (genvar g = 0; g < N; g++) begin : g_grp
        localparam int RB = run_bit(g);
        localparam int SB = strobe_bit(g);
        localparam int PB = repeat_bit(g);

        assign run_o[g]  = ctl_q[RB];
        assign rpt_o[g]  = ctl_q[PB];
        assign load_o[g] = we_i && wdata_i[SB] && !ctl_q[SB];

        // R9
        oneshot_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (hit_i[g] && !ctl_q[PB] && !we_i) |=> !ctl_q[RB]);

        // R8
        repeat_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (hit_i[g] && ctl_q[PB] && !we_i) |=> ctl_q[RB]);
    end

    always_comb begin
        clr_mask = '0;
        for (int ch = 0; ch < N; ch++) begin
            if (hit_i[ch] && !ctl_q[repeat_bit(ch)])
                clr_mask[run_bit(ch)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       ctl_q <= '0;
        else if (we_i) ctl_q <= wdata_i;
        else           ctl_q <= ctl_q & ~clr_mask;
    end

    assign ctl_o = ctl_q;

    // R3
    ctl_store_chk: assert property (@(posedge clk) disable iff (rst)
        we_i |=> ctl_q == $past(wdata_i));

endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl #(
    parameter int DW = cdt_pkg::DW,
    parameter int AW = cdt_pkg::AW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_we,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [cdt_pkg::NCH-1:0] tick_en,
    output logic [cdt_pkg::NCH-1:0] expire
);
    import cdt_pkg::*;

    reg_sel_t       sel;
    logic [DW-1:0]  cfg0_q, cfg1_q;
    logic [DW-1:0]  cntbuf_q [NCH];
    logic [DW-1:0]  cmpbuf_q [NCH];
    logic [DW-1:0]  live     [NCH];
    logic [DW-1:0]  ctl;
    logic [NCH-1:0] run, load, rpt, hit;
    logic           ctl_we;

    assign sel    = decode(bus_addr);
    assign ctl_we = bus_we && (sel.kind == SEL_CTL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg0_q <= '0;
            cfg1_q <= '0;
            for (int ch = 0; ch < NCH; ch++) begin
                cntbuf_q[ch] <= '0;
                cmpbuf_q[ch] <= '0;
            end
        end else if (bus_we) begin
            if (sel.kind == SEL_CFG0) cfg0_q <= bus_wdata;
            if (sel.kind == SEL_CFG1) cfg1_q <= bus_wdata;
            for (int ch = 0; ch < NCH; ch++) begin
                if (sel.ch == CHW'(ch)) begin
                    if (sel.kind == SEL_CNTBUF) cntbuf_q[ch] <= bus_wdata;
                    if (sel.kind == SEL_CMPBUF && ch < NCH - 1) cmpbuf_q[ch] <= bus_wdata;
                end
            end
        end
    end

    cdt_ctl #(.W(DW), .N(NCH)) ctl_i (
        .clk     (clk),
        .rst     (rst),
        .we_i    (ctl_we),
        .wdata_i (bus_wdata),
        .hit_i   (hit),
        .ctl_o   (ctl),
        .run_o   (run),
        .load_o  (load),
        .rpt_o   (rpt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cdt_chan #(.W(DW)) chan_i (
            .clk      (clk),
            .rst      (rst),
            .tick_i   (tick_en[g]),
            .run_i    (run[g]),
            .load_i   (load[g]),
            .rpt_i    (rpt[g]),
            .buf_i    (cntbuf_q[g]),
            .cnt_o    (live[g]),
            .hit_o    (hit[g]),
            .expire_o (expire[g])
        );
    end

    always_comb begin
        unique case (sel.kind)
            SEL_CFG0:   bus_rdata = cfg0_q;
            SEL_CFG1:   bus_rdata = cfg1_q;
            SEL_CTL:    bus_rdata = ctl;
            SEL_CNTBUF: bus_rdata = cntbuf_q[sel.ch];
            SEL_CMPBUF: bus_rdata = cmpbuf_q[sel.ch];
            SEL_LIVE:   bus_rdata = live[sel.ch];
            default:    bus_rdata = '0;
        endcase
    end

    // R11
    no_map_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel.kind == SEL_NONE) |=> $stable(cfg0_q) && $stable(cfg1_q) && $stable(ctl));

    // R12
    expire_run_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(expire) != 0) |-> ($countones(expire & ~$past(tick_en)) == 0));

endmodule

// File: tb/cdt_ctrl_tb.sv
module cdt_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick_en = '0;
    logic [4:0]  expire;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    logic [4:0] exp_q[$];
    logic [31:0] ctl_exp;
    logic [31:0] v;

    always #10 clk = ~clk;

    cdt_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .expire(expire)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] expv);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, expv);
    endtask

    // driver: pushes the expected expire vector before issuing the tick
    task automatic tick(input logic [4:0] m, input logic [4:0] exp_m);
        if (exp_m != '0) exp_q.push_back(exp_m);
        tick_en = m;
        @(negedge clk);
        tick_en = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req);
        #2;
        chk(req, 32'(exp_q.size()), 32'd0);
    endtask

    // monitor: every nonzero expire vector must match the next expected one
    always @(negedge clk) begin
        if (!rst && expire != '0) begin
            if (exp_q.size() == 0) chk("R7 unexpected expire", {27'd0, expire}, 32'd0);
            else chk("R7/R12 expire vector", {27'd0, expire}, {27'd0, exp_q.pop_front()});
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 cfg0", 7'h00, 0);
        rd_chk("R1 ctl", 7'h08, 0);
        rd_chk("R1 cntbuf0", 7'h0C, 0);
        rd_chk("R1 live0", 7'h14, 0);
        rd_chk("R1 live4", 7'h40, 0);
        chk("R1 expire", {27'd0, expire}, 0);

        // R2 register map
        wr(7'h00, 32'h0000_00A5);
        wr(7'h04, 32'h0000_1234);
        wr(7'h10, 32'h0000_0055);
        wr(7'h34, 32'h0000_0077);
        wr(7'h3C, 32'h0000_0009);
        rd_chk("R2 cfg0", 7'h00, 32'hA5);
        rd_chk("R2 cfg1", 7'h04, 32'h1234);
        rd_chk("R2 cmp0", 7'h10, 32'h55);
        rd_chk("R2 cmp3", 7'h34, 32'h77);
        rd_chk("R2 cntbuf4", 7'h3C, 32'h9);
        rd_chk("R2 cntbuf3 untouched", 7'h30, 0);

        // R4 reload strobe rising edge
        wr(7'h0C, 32'd3);
        wr(7'h08, 32'h2);
        ctl_exp = 32'h2;
        rd_chk("R4 live0 loaded", 7'h14, 32'd3);
        tick(5'h01, 5'h00);
        rd_chk("R5 stopped no count", 7'h14, 32'd3);
        wr(7'h0C, 32'd10);
        wr(7'h08, 32'h3);                 // strobe already 1, run rises
        ctl_exp = 32'h3;
        rd_chk("R4 no reload on level", 7'h14, 32'd3);
        tick(5'h01, 5'h00);
        rd_chk("R5 dec by one", 7'h14, 32'd2);
        idle(3);
        rd_chk("R5 no tick holds", 7'h14, 32'd2);
        tick(5'h01, 5'h00);
        tick(5'h01, 5'h00);
        rd_chk("R5 reached zero", 7'h14, 32'd0);
        tick(5'h01, 5'h01);
        drain("R7 one-shot pulse");
        ctl_exp = 32'h2;
        rd_chk("R9 run bit cleared", 7'h08, ctl_exp);
        tick(5'h01, 5'h00);
        rd_chk("R9 stays at zero", 7'h14, 32'd0);
        drain("R9 no further expire");

        // R10 + R8 on channel 1 (bits 8..11)
        wr(7'h18, 32'd2);
        ctl_exp = 32'h0000_0B02;
        wr(7'h08, ctl_exp);
        rd_chk("R10 load before count", 7'h20, 32'd2);
        tick(5'h02, 5'h00);
        rd_chk("R10 first tick from buffer", 7'h20, 32'd1);
        tick(5'h02, 5'h00);
        tick(5'h02, 5'h02);
        drain("R8 repeat pulse");
        rd_chk("R8 refilled", 7'h20, 32'd2);
        rd_chk("R8 run kept", 7'h08, ctl_exp);
        tick(5'h02, 5'h00);
        rd_chk("R8 keeps running", 7'h20, 32'd1);
        rd_chk("R12 ch0 undisturbed", 7'h14, 32'd0);

        // R6 stop holds
        ctl_exp = 32'h0000_0A02;
        wr(7'h08, ctl_exp);
        tick(5'h02, 5'h00);
        tick(5'h02, 5'h00);
        rd_chk("R6 held when stopped", 7'h20, 32'd1);

        // R3 channel 4 group at 20, repeat at bit 22
        wr(7'h3C, 32'd1);
        ctl_exp = 32'h0070_0A02;
        wr(7'h08, ctl_exp);
        rd_chk("R3 ch4 loaded", 7'h40, 32'd1);
        tick(5'h10, 5'h00);
        tick(5'h10, 5'h10);
        drain("R3 ch4 expire");
        rd_chk("R3 ch4 bit22 repeats", 7'h40, 32'd1);
        rd_chk("R3 ch4 run kept", 7'h08, ctl_exp);

        // R3 channel 3 group at 16, one-shot from count 0
        ctl_exp = 32'h0073_0A02;
        wr(7'h08, ctl_exp);
        tick(5'h08, 5'h08);
        drain("R3 ch3 expire");
        ctl_exp = 32'h0072_0A02;
        rd_chk("R3 ch3 run cleared", 7'h08, ctl_exp);

        // R3 channel 2 group at 12, repeat bit 15
        ctl_exp = 32'h0072_9A02;
        wr(7'h08, ctl_exp);
        tick(5'h04, 5'h04);
        rd_chk("R3 ch2 run kept", 7'h08, ctl_exp);
        // R12 simultaneous expiries
        tick(5'h14, 5'h04);
        rd_chk("R12 ch4 counted", 7'h40, 32'd0);
        tick(5'h14, 5'h14);
        drain("R12 joint expire");
        rd_chk("R12 ch4 refilled", 7'h40, 32'd1);

        // R11 unmapped and misaligned
        wr(7'h44, 32'hFFFF_FFFF);
        wr(7'h48, 32'hFFFF_FFFF);
        wr(7'h01, 32'hFFFF_FFFF);
        wr(7'h0D, 32'hFFFF_FFFF);
        wr(7'h14, 32'hFFFF_FFFF);
        rd_chk("R11 read 0x44", 7'h44, 0);
        rd_chk("R11 read 0x48", 7'h48, 0);
        rd_chk("R11 read misaligned", 7'h0D, 0);
        rd_chk("R11 cfg0 intact", 7'h00, 32'hA5);
        rd_chk("R11 ctl intact", 7'h08, ctl_exp);
        rd_chk("R11 cntbuf0 intact", 7'h0C, 32'd10);
        rd_chk("R11 live0 intact", 7'h14, 32'd0);

        idle(2);
        drain("R7 final queue empty");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule